// File: doc/BRIEF.md
# Parcel Instruction Cache

This block is a read-only, direct-mapped instruction cache. It sits in front of a fetch stage that handles compressed code, so it returns one 16-bit parcel per cycle. The parcel can sit at any halfword address. Each access reads exactly one parcel from exactly one cache block, so an access never reaches into a second block. On a miss, the cache requests the whole block from instruction memory and loads it before it answers the fetch. The block length and the total capacity are parameters.

When the capacity parameter is zero, the block holds no storage. Each fetch then becomes a single-parcel memory read, and the fetch side receives the returned parcel in the same cycle that it arrives. A one-cycle flush input invalidates every line at once. Aligning and assembling 32-bit instructions out of parcels is the job of the fetch stage, not of this block.

Top module: `parcel_icache`

## Requirements
- R1: On a hit, `f_ready` is high in the same cycle that `f_valid` is high, and `f_parcel` carries the stored parcel for `f_addr`. `f_ready` is never high without `f_valid`.
- R2: `f_addr` is a byte address whose bit 0 is ignored. The parcel inside a block is selected by bits [OFF_W-1:1], where OFF_W = log2(BLOCK_BYTES).
- R3: A miss raises `mem_req` for exactly one cycle. In that cycle `mem_addr` is the block-aligned address of the missing block. Memory then returns BLOCK_BYTES/2 beats on `mem_rvalid`/`mem_rdata`, in order starting from the lowest parcel of the block.
- R4: `f_ready` stays low while a refill is in progress. The waiting fetch is answered in the cycle after the last beat is taken. This means a miss completes 3 + latency + BLOCK_BYTES/2 cycles after it is presented.
- R5: A fetch of the last parcel of one block, followed by a fetch of the first parcel of the next block, refills the second block on its own. The first block is not refilled.
- R6: The cache is direct-mapped. The line index is bits [OFF_W+IDX_W-1:OFF_W], and the upper bits form the tag. Two blocks with the same index and different tags evict each other.
- R7: A cycle with `flush` high clears every valid bit. From the next cycle, every fetch misses.
- R8: With CACHE_BYTES = 0, every fetch issues one `mem_req` whose address is `f_addr` with bit 0 cleared. `f_ready` is high exactly in the cycle of the single returned beat, and `f_parcel` equals `mem_rdata`. Nothing is retained between fetches.
- R9: After reset, all lines are invalid, and `f_ready` and `mem_req` are low while no fetch is presented.
- R10: A jump into the middle of an uncached block refills that whole block from its start and returns the parcel at the jump target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| f_valid | input | 1 | Fetch request present |
| f_addr | input | ADDR_W | Fetch byte address |
| f_ready | output | 1 | Parcel delivered this cycle |
| f_parcel | output | 16 | Delivered parcel |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | ADDR_W | Block (or parcel, when bypassed) address |
| mem_rvalid | input | 1 | Memory beat valid |
| mem_rdata | input | 16 | Memory beat data |

## Verification
The bench applies three kinds of fetch sequence.

- **Straight-line sequence that walks a block and steps into the next.** This separates a correct per-parcel offset select from a stale or shifted one. It also shows that the block boundary triggers a new refill.
- **Jump into the middle of a block whose index is already occupied, then a return to the evicted block.** This separates refill ordering from the beat order and exposes the tag comparison.
- **Odd addresses and repeated fetches in the storage-free configuration.** These show that bit 0 is ignored and that nothing is cached when the capacity is zero.

A flush between two fetches of the same parcel separates a true invalidate from a refill that never happened.

// File: rtl/parcel_icache.sv
module parcel_icache #(
  parameter int ADDR_W      = 12,
  parameter int CACHE_BYTES = 32,
  parameter int BLOCK_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              f_valid,
  input  logic [ADDR_W-1:0] f_addr,
  output logic              f_ready,
  output logic [15:0]       f_parcel,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata
);
  localparam int PARCELS = BLOCK_BYTES / 2;
  localparam int OFF_W   = $clog2(BLOCK_BYTES);
  localparam int PW      = OFF_W - 1;
  localparam int LINES   = (CACHE_BYTES == 0) ? 2 : CACHE_BYTES / BLOCK_BYTES;
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;

  logic unused_bits;
  assign unused_bits = f_addr[0] ^ flush;

  if (CACHE_BYTES == 0) begin : g_byp
    logic waiting_q;
    assign mem_req  = f_valid && !waiting_q;
    assign mem_addr = {f_addr[ADDR_W-1:1], 1'b0};
    assign f_ready  = waiting_q && mem_rvalid;
    assign f_parcel = mem_rdata;

    always_ff @(posedge clk) begin
      if (!rst_n)          waiting_q <= 1'b0;
      else if (mem_req)    waiting_q <= 1'b1;
      else if (mem_rvalid) waiting_q <= 1'b0;
    end
  end else begin : g_cache
    typedef enum logic {S_IDLE, S_FILL} st_t;
    st_t              st_q;
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [15:0]      data_q [LINES][PARCELS];
    logic [IDX_W-1:0] fill_idx_q;
    logic [TAG_W-1:0] fill_tag_q;
    logic [PW-1:0]    beat_q;

    wire [IDX_W-1:0] idx  = f_addr[OFF_W +: IDX_W];
    wire [TAG_W-1:0] tag  = f_addr[ADDR_W-1 -: TAG_W];
    wire [PW-1:0]    par  = f_addr[1 +: PW];
    wire             hit  = valid_q[idx] && (tag_q[idx] == tag);
    wire             take = (st_q == S_FILL) && mem_rvalid;
    wire             last = take && (beat_q == PW'(PARCELS - 1));

    assign f_ready  = (st_q == S_IDLE) && f_valid && hit;
    assign f_parcel = data_q[idx][par];
    assign mem_req  = (st_q == S_IDLE) && f_valid && !hit;
    assign mem_addr = {tag, idx, {OFF_W{1'b0}}};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q       <= S_IDLE;
        valid_q    <= '0;
        beat_q     <= '0;
        fill_idx_q <= '0;
        fill_tag_q <= '0;
      end else begin
        if (mem_req) begin
          st_q       <= S_FILL;
          fill_idx_q <= idx;
          fill_tag_q <= tag;
          beat_q     <= '0;
        end else if (take) begin
          beat_q <= beat_q + 1'b1;
          if (last) st_q <= S_IDLE;
        end
        if (flush)     valid_q <= '0;
        else if (last) valid_q[fill_idx_q] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (take) data_q[fill_idx_q][beat_q] <= mem_rdata;
      if (last) tag_q[fill_idx_q] <= fill_tag_q;
    end
  end
endmodule

// File: rtl/parcel_icache_chk.sv
module parcel_icache_chk #(
  parameter int ADDR_W      = 12,
  parameter int CACHE_BYTES = 32,
  parameter int BLOCK_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              f_valid,
  input logic              f_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid
);
  localparam bit              BYP   = (CACHE_BYTES == 0);
  localparam logic [ADDR_W-1:0] AMASK = BYP ? ADDR_W'(1) : ADDR_W'(BLOCK_BYTES - 1);

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    f_ready |-> f_valid) else $error("ready without valid"); // R1
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr & AMASK) == '0)) else $error("request misaligned"); // R3
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req) else $error("request longer than one cycle"); // R3
  AST_NO_READY_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && !BYP) |-> !f_ready) else $error("ready during refill"); // R4
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !BYP) |=> !f_ready) else $error("hit after flush"); // R7
  AST_BYP_READY_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (f_ready && BYP) |-> mem_rvalid) else $error("bypass ready without beat"); // R8
endmodule

bind parcel_icache parcel_icache_chk #(
  .ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES), .BLOCK_BYTES(BLOCK_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .f_valid(f_valid), .f_ready(f_ready),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid)
);

// File: tb/parcel_icache_tb_top.sv
module icache_mem_model #(parameter int BEATS = 4, parameter int LAT = 2) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [11:0] addr,
  output logic        rvalid,
  output logic [15:0] rdata,
  output int          req_count,
  output logic [11:0] last_addr
);
  logic [11:0] base;
  int cnt, dly;
  logic busy;

  function automatic logic [15:0] pv(input logic [11:0] a);
    return {a[11:1], 5'b10110};
  endfunction

  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (!rst_n) begin
      busy <= 1'b0; req_count <= 0; last_addr <= '0; cnt <= 0; dly <= 0;
    end else if (req) begin
      base <= addr; last_addr <= addr; busy <= 1'b1; cnt <= 0; dly <= LAT;
      req_count <= req_count + 1;
    end else if (busy) begin
      if (dly > 0) dly <= dly - 1;
      else begin
        rvalid <= 1'b1;
        rdata  <= pv(base + 12'(2 * cnt));
        cnt    <= cnt + 1;
        if (cnt == BEATS - 1) busy <= 1'b0;
      end
    end
  end
endmodule

module parcel_icache_tb_top;
  localparam int LAT = 2;
  localparam int PARCELS = 4;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [11:0] fa = '0;
  logic fv_c = 0, fv_b = 0;
  logic rdy_c, rdy_b, req_c, req_b, rv_c, rv_b;
  logic [15:0] par_c, par_b, rd_c, rd_b;
  logic [11:0] ma_c, ma_b, la_c, la_b;
  int rc_c, rc_b;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  parcel_icache #(.ADDR_W(12), .CACHE_BYTES(32), .BLOCK_BYTES(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .f_valid(fv_c), .f_addr(fa),
    .f_ready(rdy_c), .f_parcel(par_c), .mem_req(req_c), .mem_addr(ma_c),
    .mem_rvalid(rv_c), .mem_rdata(rd_c));
  icache_mem_model #(.BEATS(PARCELS), .LAT(LAT)) mem_c (
    .clk(clk), .rst_n(rst_n), .req(req_c), .addr(ma_c), .rvalid(rv_c),
    .rdata(rd_c), .req_count(rc_c), .last_addr(la_c));

  parcel_icache #(.ADDR_W(12), .CACHE_BYTES(0), .BLOCK_BYTES(8)) dut_byp_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .f_valid(fv_b), .f_addr(fa),
    .f_ready(rdy_b), .f_parcel(par_b), .mem_req(req_b), .mem_addr(ma_b),
    .mem_rvalid(rv_b), .mem_rdata(rd_b));
  icache_mem_model #(.BEATS(1), .LAT(LAT)) mem_b (
    .clk(clk), .rst_n(rst_n), .req(req_b), .addr(ma_b), .rvalid(rv_b),
    .rdata(rd_b), .req_count(rc_b), .last_addr(la_b));

  function automatic logic [15:0] pv(input logic [11:0] a);
    return {a[11:1], 5'b10110};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bit 12 = expected miss, bits 11:0 = fetch address
  localparam logic [12:0] VEC [11] = '{
    {1'b1, 12'h000},  // R3 R10 cold block, first parcel
    {1'b0, 12'h002},  // R1 R2 straight-line hit
    {1'b0, 12'h004},  // R1
    {1'b0, 12'h006},  // R5 last parcel of block 0
    {1'b1, 12'h008},  // R5 next block refilled alone
    {1'b0, 12'h00A},  // R1
    {1'b1, 12'h0E6},  // R10 jump to mid-block, same index as 0x000 (R6)
    {1'b0, 12'h0E4},  // R10 whole block present
    {1'b1, 12'h000},  // R6 evicted by 0x0E0
    {1'b0, 12'h00B},  // R2 odd address hits parcel 0x00A
    {1'b0, 12'h007}   // R2 odd address hits parcel 0x006
  };

  task automatic fetch(input bit byp, input logic [11:0] a, input bit miss);
    int waits = 0;
    int rc0 = byp ? rc_b : rc_c;
    int exp_waits = byp ? (2 + LAT + 1) : (miss ? (3 + LAT + PARCELS) : 1);
    logic [15:0] got = '0;
    bit done = 0;
    fa = a;
    if (byp) fv_b = 1; else fv_c = 1;
    while (!done && waits < 100) begin
      @(negedge clk);
      waits++;
      if (byp ? rdy_b : rdy_c) begin
        got = byp ? par_b : par_c;
        done = 1;
      end else @(posedge clk);
    end
    @(posedge clk); #1;
    fv_b = 0; fv_c = 0;
    check(waits == exp_waits, byp ? "R8 ready timing" : (miss ? "R4 refill stall" : "R1 hit timing"),
          waits, exp_waits);
    check(got == pv({a[11:1], 1'b0}), byp ? "R8 bypass parcel" : "R2 parcel select",
          got, pv({a[11:1], 1'b0}));
    check(((byp ? rc_b : rc_c) - rc0) == (miss ? 1 : 0), byp ? "R8 request count" : "R3 request count",
          (byp ? rc_b : rc_c) - rc0, miss ? 1 : 0);
    if (miss) begin
      logic [11:0] ea = byp ? {a[11:1], 1'b0} : {a[11:3], 3'b000};
      check((byp ? la_b : la_c) == ea, byp ? "R8 request address" : "R3 block address",
            byp ? la_b : la_c, ea);
    end
  endtask

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!rdy_c && !req_c && !rdy_b && !req_b, "R9 idle after reset", {rdy_c, req_c, rdy_b, req_b}, 0);
    @(posedge clk); #1;

    for (int i = 0; i < 11; i++) fetch(1'b0, VEC[i][11:0], VEC[i][12]);

    // R7: flush invalidates the resident block holding 0x00A
    flush = 1; @(posedge clk); #1; flush = 0;
    fetch(1'b0, 12'h00A, 1'b1); // R7 refetch misses
    fetch(1'b0, 12'h00C, 1'b0); // R7 refilled block hits again

    // R8: storage-free mode, every fetch goes to memory
    fetch(1'b1, 12'h013, 1'b1);
    fetch(1'b1, 12'h013, 1'b1); // R8 no retention
    fetch(1'b1, 12'h7FE, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule